// File: doc/BRIEF.md
# Five-Level Stacked-Carrier Sine PWM Gate Generator

This block drives the six switches of a single-phase five-level bridge. The bridge is an H-bridge with an extra bidirectional switch pair that adds a half-supply tap. A phase accumulator with a folded quarter-wave table produces a signed sine reference, and a modulation-index word scales it. Two stacked triangular carriers slice the reference magnitude. The lower carrier covers the span from zero to half scale, and the upper carrier covers the span from half scale to full scale. The negative half-cycle uses the same bands in mirror image.

The slicer picks one of five output levels and registers it together with its six gate enables. All six gates therefore change in the same clock cycle. A build-time parameter selects how the carriers in the four bands are phased against each other. New modulation, frequency and carrier-period words take effect only in a cycle where the carrier sits at its valley, so a carrier period never mixes two settings.

Top module: `mlpwm_top`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `gate` is 6'b000000 and `level` is 3'b000.
- R2: The level code is sign-magnitude: 000 zero, 001 +half, 010 +full, 101 −half, 110 −full. `gate` bit i drives switch S(i+1). Each code maps to its switches as follows: +full → S1,S4 (6'b001001); +half → S4,S6 (6'b101000); zero → S3,S4 (6'b001100); −half → S2,S3 (6'b000110); −full → S2,S5 (6'b010010).
- R3: The carrier count c starts at 0, steps up by one per clock to the period word P, then steps down to 0. A full triangle is 2P clocks, with P ≥ 1.
- R4: The phase advances by the frequency word every clock, modulo 2^16. The top two phase bits give the quadrant: bit 0 mirrors the 6-bit table index and bit 1 makes the sample negative. The table entry for index q is floor((2q+1)(256−(2q+1))·2047 / 16384).
- R5: With sample magnitude m and index word a, let u = m·a, H = 2^18 and L = u·P. The result is the full level if L > (P+kh)·H, else the half level if L > kl·H, else zero. The comparisons are strict. The sign comes from the quadrant, and a zero result is always code 000.
- R6: The disposition parameter sets the band counts, with c′ = P−c. Phase disposition: kl = kh = c for a positive sample and c′ for a negative one. Phase opposition: kl = kh = c. Alternate opposition: kl = c′ and kh = c.
- R7: For an index word at or below 128 (0.5 of 256), no full level appears. At 255 both full and half levels appear.
- R8: The index, frequency and period words are taken only in a cycle where c = 0, and they take effect in that same cycle. At other times changes are held off.
- R9: `level` and `gate` are registered. Both reflect the carrier and phase state of the cycle before the clock edge.
- R10: After reset, exactly two gates are on at all times, and S1 and S2 are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ma_word | input | MA_W (8) | Modulation index, 256 = 1.0 |
| freq_word | input | PH_W (16) | Phase step per clock |
| per_word | input | PER_W (16) | Carrier half-period in clocks |
| gate | output | 6 | Gate enables for S1..S6 (bit 0 = S1) |
| level | output | 3 | Selected level code |

## Verification
Every result appears one clock after the state that produced it. The bench advances an arithmetic model of the phase, the carrier and the latched words once per clock on the falling edge. It then compares `level` and `gate` on the next falling edge, after the rising edge that registered them. Word changes are applied at arbitrary points in the carrier. The model holds them until the next valley cycle, so any early or late take-up shows up as a level mismatch on the following sample. The three disposition variants run side by side on identical stimulus, and each is compared against its own band rule.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

   typedef enum logic [1:0] {DISP_PD, DISP_POD, DISP_APOD} disp_e;

   typedef enum logic [2:0] {
      LV_ZERO = 3'b000,
      LV_PH   = 3'b001,
      LV_PF   = 3'b010,
      LV_NH   = 3'b101,
      LV_NF   = 3'b110
   } lvl_e;

   // switch pattern for each level; bit i drives switch S(i+1)
   function automatic logic [5:0] gates_of(logic [2:0] code);
      case (code)
         LV_PF:   return 6'b001001;
         LV_PH:   return 6'b101000;
         LV_NH:   return 6'b000110;
         LV_NF:   return 6'b010010;
         default: return 6'b001100;
      endcase
   endfunction

   // parabolic quarter-wave magnitude for table index q
   function automatic longint qw_amp(int q, int qw, int sw);
      longint m2, t, amax;
      m2   = longint'(1) << (qw + 2);
      t    = longint'(2 * q + 1);
      amax = (longint'(1) << (sw - 1)) - 1;
      return (t * (m2 - t) * amax) >> (2 * qw + 2);
   endfunction

endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PER_W-1:0] period,
   output logic [PER_W-1:0] count,
   output logic             valley
);
   logic             rising;
   logic [PER_W:0]   nxt_up;

   assign nxt_up = {1'b0, count} + 1'b1;
   assign valley = (count == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         count  <= '0;
         rising <= 1'b1;
      end else if (rising) begin
         count <= nxt_up[PER_W-1:0];
         if (nxt_up >= {1'b0, period}) rising <= 1'b0;
      end else begin
         count <= count - 1'b1;
         if (count == PER_W'(1)) rising <= 1'b1;
      end
   end
endmodule

// File: rtl/mlpwm_sine.sv
module mlpwm_sine #(
   parameter int PH_W  = 16,
   parameter int Q_W   = 6,
   parameter int SMP_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PH_W-1:0]  step,
   output logic [SMP_W-2:0] mag,
   output logic             neg
);
   import mlpwm_pkg::*;
   localparam int DEPTH = 1 << Q_W;

   logic [PH_W-1:0]  phase;
   logic [1:0]       quad;
   logic [Q_W-1:0]   raw, idx;
   logic [SMP_W-2:0] rom [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_rom
      localparam longint AMP = qw_amp(g, Q_W, SMP_W);
      assign rom[g] = AMP[SMP_W-2:0];
   end

   always_ff @(posedge clk) begin
      if (rst) phase <= '0;
      else     phase <= phase + step;
   end

   assign quad = phase[PH_W-1 -: 2];
   assign raw  = phase[PH_W-3 -: Q_W];
   assign idx  = quad[0] ? ~raw : raw;
   assign mag  = rom[idx];
   assign neg  = quad[1];
endmodule

// File: rtl/mlpwm_slicer.sv
module mlpwm_slicer
   import mlpwm_pkg::*;
#(
   parameter int    SMP_W = 12,
   parameter int    MA_W  = 8,
   parameter int    PER_W = 16,
   parameter disp_e DISP  = DISP_PD
) (
   input  logic [SMP_W-2:0] mag,
   input  logic             neg,
   input  logic [MA_W-1:0]  ma,
   input  logic [PER_W-1:0] period,
   input  logic [PER_W-1:0] count,
   output logic [2:0]       level
);
   localparam int SH    = SMP_W - 1 + MA_W - 1;
   localparam int CMP_W = SMP_W - 1 + MA_W + PER_W + 1;

   logic             inv_lo, inv_hi;
   logic [PER_W-1:0] c_rev, k_lo, k_hi;
   logic [CMP_W-1:0] lhs, thr_lo, thr_hi;
   logic [1:0]       step;

   if (DISP == DISP_PD) begin : g_pd
      assign inv_lo = neg;
      assign inv_hi = neg;
   end else if (DISP == DISP_POD) begin : g_pod
      assign inv_lo = 1'b0;
      assign inv_hi = 1'b0;
   end else begin : g_apod
      assign inv_lo = 1'b1;
      assign inv_hi = 1'b0;
   end

   assign c_rev  = period - count;
   assign k_lo   = inv_lo ? c_rev : count;
   assign k_hi   = inv_hi ? c_rev : count;
   assign lhs    = CMP_W'(mag) * CMP_W'(ma) * CMP_W'(period);
   assign thr_lo = CMP_W'(k_lo) << SH;
   assign thr_hi = (CMP_W'(period) + CMP_W'(k_hi)) << SH;

   always_comb begin
      if (lhs > thr_hi)      step = 2'd2;
      else if (lhs > thr_lo) step = 2'd1;
      else                   step = 2'd0;
      level = (step == 2'd0) ? 3'b000 : {neg, 1'b0, 1'b0} | {1'b0, step};
   end
endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
   import mlpwm_pkg::*;
#(
   parameter int    PH_W  = 16,
   parameter int    Q_W   = 6,
   parameter int    SMP_W = 12,
   parameter int    MA_W  = 8,
   parameter int    PER_W = 16,
   parameter disp_e DISP  = DISP_PD
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [MA_W-1:0]  ma_word,
   input  logic [PH_W-1:0]  freq_word,
   input  logic [PER_W-1:0] per_word,
   output logic [5:0]       gate,
   output logic [2:0]       level
);
   if (Q_W + 2 > PH_W) begin : g_bad_phase
      $error("table index wider than phase allows");
   end
   if (SMP_W < 4 || MA_W < 2) begin : g_bad_width
      $error("sample or index word too narrow");
   end

   logic [MA_W-1:0]  ma_q, ma_eff;
   logic [PH_W-1:0]  freq_q, freq_eff;
   logic [PER_W-1:0] per_q, per_eff, cnt;
   logic             valley, neg;
   logic [SMP_W-2:0] mag;
   logic [2:0]       lvl_d;

   // words are taken only at a carrier valley
   assign ma_eff   = valley ? ma_word   : ma_q;
   assign freq_eff = valley ? freq_word : freq_q;
   assign per_eff  = valley ? per_word  : per_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ma_q   <= '0;
         freq_q <= '0;
         per_q  <= '0;
      end else begin
         ma_q   <= ma_eff;
         freq_q <= freq_eff;
         per_q  <= per_eff;
      end
   end

   mlpwm_carrier #(.PER_W(PER_W)) u_car (
      .clk(clk), .rst(rst), .period(per_eff), .count(cnt), .valley(valley)
   );

   mlpwm_sine #(.PH_W(PH_W), .Q_W(Q_W), .SMP_W(SMP_W)) u_sin (
      .clk(clk), .rst(rst), .step(freq_eff), .mag(mag), .neg(neg)
   );

   mlpwm_slicer #(.SMP_W(SMP_W), .MA_W(MA_W), .PER_W(PER_W), .DISP(DISP)) u_slc (
      .mag(mag), .neg(neg), .ma(ma_eff), .period(per_eff), .count(cnt), .level(lvl_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         level <= LV_ZERO;
         gate  <= '0;
      end else begin
         level <= lvl_d;
         gate  <= gates_of(lvl_d);
      end
   end
endmodule

// File: rtl/mlpwm_chk.sv
module mlpwm_chk
   import mlpwm_pkg::*;
#(
   parameter int MA_W  = 8,
   parameter int PER_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic [5:0]       gate,
   input logic [2:0]       level,
   input logic [MA_W-1:0]  ma_q,
   input logic [PER_W-1:0] per_q,
   input logic [PER_W-1:0] cnt
);
   localparam logic [MA_W-1:0] HALF = MA_W'(1) << (MA_W - 1);

   a_r2_map: assert property (@(posedge clk) disable iff (rst)
      (gate != 6'd0) |-> (gate == gates_of(level)));

   a_r10_leg: assert property (@(posedge clk) disable iff (rst)
      !(gate[0] && gate[1]));

   a_r10_pair: assert property (@(posedge clk) disable iff (rst)
      (gate != 6'd0) |-> ($countones(gate) == 2));

   a_r3_bound: assert property (@(posedge clk) disable iff (rst)
      (cnt <= per_q) || (cnt == '0));

   a_r3_turn: assert property (@(posedge clk) disable iff (rst)
      (cnt == per_q && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   a_r7_three: assert property (@(posedge clk) disable iff (rst)
      (ma_q <= HALF) |-> (level[1] == 1'b0));
endmodule

bind mlpwm_top mlpwm_chk #(.MA_W(MA_W), .PER_W(PER_W)) u_chk (
   .clk(clk), .rst(rst), .gate(gate), .level(level),
   .ma_q(ma_q), .per_q(per_q), .cnt(cnt)
);

// File: tb/sim_mlpwm_top.sv
module sim_mlpwm_top;
   import mlpwm_pkg::*;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  ma_word = '0;
   logic [15:0] freq_word = '0;
   logic [15:0] per_word = '0;
   logic [5:0]  gt [3];
   logic [2:0]  lv [3];

   int n_chk = 0, n_err = 0;
   int full_lo = 0, full_hi = 0, half_hi = 0, diff01 = 0, diff12 = 0;
   bit in_lo = 0, in_hi = 0, done = 0;

   // model state
   int m_cnt = 0, m_up = 1, m_per = 0, m_freq = 0, m_ma = 0, m_ph = 0;
   int exp_lv [3];

   always #(CLK_P/2) clk = ~clk;

   mlpwm_top #(.DISP(DISP_PD))   u0 (.clk(clk), .rst(rst), .ma_word(ma_word),
      .freq_word(freq_word), .per_word(per_word), .gate(gt[0]), .level(lv[0]));
   mlpwm_top #(.DISP(DISP_POD))  u1 (.clk(clk), .rst(rst), .ma_word(ma_word),
      .freq_word(freq_word), .per_word(per_word), .gate(gt[1]), .level(lv[1]));
   mlpwm_top #(.DISP(DISP_APOD)) u2 (.clk(clk), .rst(rst), .ma_word(ma_word),
      .freq_word(freq_word), .per_word(per_word), .gate(gt[2]), .level(lv[2]));

   function automatic int exp_gates(int c);
      case (c)
         2: return 6'b001001;
         1: return 6'b101000;
         5: return 6'b000110;
         6: return 6'b010010;
         default: return 6'b001100;
      endcase
   endfunction

   task automatic check(string tag, int act, int expv);
      n_chk++;
      if (act != expv) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // R4 parabolic table, R5 threshold rule, R6 band phasing
   function automatic int model_level(int mode, int ph, int cnt, int p, int a);
      int quad, raw, idx, ng, kl, kh, st;
      longint t, m, l;
      quad = (ph >> 14) & 3;
      raw  = (ph >> 8) & 63;
      idx  = (quad & 1) ? 63 - raw : raw;
      ng   = quad >> 1;
      t    = 2 * idx + 1;
      m    = (t * (256 - t) * 2047) >> 14;
      l    = m * a * p;
      if (mode == 0)      begin kl = ng ? p - cnt : cnt; kh = kl; end
      else if (mode == 1) begin kl = cnt; kh = cnt; end
      else                begin kl = p - cnt; kh = cnt; end
      if (l > (longint'(p + kh) << 18))   st = 2;
      else if (l > (longint'(kl) << 18))  st = 1;
      else                                st = 0;
      return (st == 0) ? 0 : (ng * 4 + st);
   endfunction

   // one clock of the model: R8 valley take-up, R3 carrier, R4 phase
   task automatic model_step();
      int pe, fe, me, n;
      bit v;
      v  = (m_cnt == 0);
      pe = v ? int'(per_word)  : m_per;
      fe = v ? int'(freq_word) : m_freq;
      me = v ? int'(ma_word)   : m_ma;
      for (int k = 0; k < 3; k++) exp_lv[k] = model_level(k, m_ph, m_cnt, pe, me);
      m_per = pe; m_freq = fe; m_ma = me;
      m_ph  = (m_ph + fe) & 16'hFFFF;
      if (m_up != 0) begin
         n = m_cnt + 1;
         if (n >= pe) m_up = 0;
      end else begin
         n = m_cnt - 1;
         if (n == 0) m_up = 1;
      end
      m_cnt = n & 16'hFFFF;
   endtask

   task automatic run(int p, int f, int a, int cycles);
      per_word = 16'(p); freq_word = 16'(f); ma_word = 8'(a);
      for (int i = 0; i < cycles; i++) begin
         model_step();
         @(negedge clk);
         for (int k = 0; k < 3; k++) begin
            // R9 one-cycle latency, R5 R6 R8 level value
            check($sformatf("R5 R6 R8 R9 level u%0d", k), lv[k], exp_lv[k]);
            check($sformatf("R2 gates u%0d", k), gt[k], exp_gates(exp_lv[k]));
            // R10 leg safety
            check($sformatf("R10 leg u%0d", k), int'(gt[k][0] & gt[k][1]), 0);
            if (lv[k][1] && in_lo) full_lo++;
            if (lv[k][1] && in_hi) full_hi++;
            if (lv[k] inside {3'b001, 3'b101} && in_hi) half_hi++;
         end
         if (lv[0] != lv[1]) diff01++;
         if (lv[1] != lv[2]) diff12++;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         check("R1 reset level", lv[k], 0);
         check("R1 reset gates", gt[k], 0);
      end
      rst = 1'b0;
      run(4, 512, 0, 300);
      in_lo = 1;
      run(3, 700, 128, 600);
      run(6, 900, 100, 500);
      in_lo = 0; in_hi = 1;
      run(7, 256, 255, 900);
      in_hi = 0;
      run(2, 1000, 200, 500);
      run(20, 300, 255, 1200);
      run(5, 2048, 180, 400);
      run(1, 4000, 230, 300);
      check("R7 no full level at index<=half", full_lo, 0);
      check("R7 full level reached at max index", int'(full_hi > 0), 1);
      check("R7 half level present at max index", int'(half_hi > 0), 1);
      check("R6 PD differs from POD", int'(diff01 > 0), 1);
      check("R6 POD differs from APOD", int'(diff12 > 0), 1);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule